// File: doc/BRIEF.md
# Modulo-6 Up Counter with Illegal-State Recovery

This block is a synchronous three-bit counter that visits the values zero through five in order and returns to zero after five, advancing only on rising clock edges where its enable is high. It is a Moore machine: the count value and the carry flag decode the registered state alone, so neither output has a combinational path from the enable. The carry flag is high for as long as the counter rests at zero, and it drops when the count moves on to one.

The six valid states are named ST_ZERO, ST_ONE, ST_TWO, ST_THREE, ST_FOUR and ST_FIVE, and each is encoded with its own count value. The two spare codes are named ST_BAD6 (110) and ST_BAD7 (111). The transitions are as follows:
- STEP moves from one valid state to the next while the enable is high.
- WRAP moves from ST_FIVE to ST_ZERO while the enable is high.
- HOLD keeps the present valid state while the enable is low.
- RECOVER moves from either spare code to ST_ZERO on the very next edge, whatever the enable.

While the counter sits in a spare code, it drives the value 111 with carry low, so the surrounding logic can see the fault. A test preload input lets a bench place the register in any code, including the spare ones.

Top module: `mod6_counter`

## Requirements
- R1: A synchronous active-high reset puts the counter in ST_ZERO, so count_val reads 000 and carry reads 1 after the edge. Reset has priority over the preload and over counting.
- R2: When cnt_en is 1 on a rising edge and the state is ST_ZERO through ST_FOUR, the count advances by exactly one.
- R3: When cnt_en is 1 on a rising edge in ST_FIVE, the counter wraps to ST_ZERO (count_val 000, carry 1).
- R4: When cnt_en is 0 on a rising edge in a valid state, the state and both outputs keep their values.
- R5: carry is 1 exactly when the state is ST_ZERO, and it stays 1 through any number of held cycles at zero.
- R6: In every valid state, count_val equals the state code (binary 000 to 101).
- R7: From ST_BAD6 or ST_BAD7, the next rising edge returns the counter to ST_ZERO for both values of cnt_en.
- R8: While the state is ST_BAD6 or ST_BAD7, count_val is 111 and carry is 0.
- R9: When tst_load is 1 on a rising edge (and reset is low), the state takes the code on tst_state, and cnt_en has no effect on that edge.
- R10: Both outputs depend only on the registered state. A change of cnt_en between edges changes neither count_val nor carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to ST_ZERO |
| cnt_en | input | 1 | Advance enable (1 = step, 0 = hold) |
| tst_load | input | 1 | Test preload strobe; loads tst_state on the edge |
| tst_state | input | 3 | Raw state code to preload, spare codes allowed |
| count_val | output | 3 | Count value, or 111 in a spare code |
| carry | output | 1 | High only while the count is zero |

## Verification
One table of enable patterns runs the counter through two full laps. Runs of high enable separate step from wrap. Single and double low cycles at zero and at non-zero values separate hold from step, and show that carry persists at zero but not elsewhere. Each spare code is then preloaded and left with cnt_en low and with cnt_en high, which shows that recovery ignores the enable and that the error pattern appears for exactly one cycle. Toggling cnt_en between edges tells a Moore output apart from an enable-dependent one. Preloading a valid code with cnt_en high, and asserting reset together with the preload, settle the priority among reset, preload and counting.

// File: rtl/mod6_pkg.sv
package mod6_pkg;
    localparam int CNT_W   = 3;
    localparam int MOD_N   = 6;
    localparam int LAST_V  = MOD_N - 1;
    localparam logic [CNT_W-1:0] ERR_PATTERN = '1;

    typedef enum logic [CNT_W-1:0] {
        ST_ZERO  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_THREE = 3'd3,
        ST_FOUR  = 3'd4,
        ST_FIVE  = 3'd5,
        ST_BAD6  = 3'd6,
        ST_BAD7  = 3'd7
    } state_t;
endpackage

// File: rtl/mod6_next.sv
module mod6_next
    import mod6_pkg::*;
(
    input  state_t           cur,
    input  logic             rst,
    input  logic             en,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_code,
    output state_t           nxt
);
    state_t step_target;

    // successor of each state when enabled
    always_comb begin
        unique case (cur)
            ST_ZERO:  step_target = ST_ONE;
            ST_ONE:   step_target = ST_TWO;
            ST_TWO:   step_target = ST_THREE;
            ST_THREE: step_target = ST_FOUR;
            ST_FOUR:  step_target = ST_FIVE;
            ST_FIVE:  step_target = ST_ZERO;   // WRAP
            ST_BAD6:  step_target = ST_ZERO;   // RECOVER
            ST_BAD7:  step_target = ST_ZERO;   // RECOVER
        endcase
    end

    always_comb begin
        if (rst) begin
            nxt = ST_ZERO;
        end else if (ld) begin
            nxt = state_t'(ld_code);
        end else begin
            unique case (cur)
                ST_BAD6, ST_BAD7: nxt = ST_ZERO;
                default:          nxt = en ? step_target : cur;   // STEP / HOLD
            endcase
        end
    end
endmodule

// File: rtl/mod6_decode.sv
module mod6_decode
    import mod6_pkg::*;
(
    input  state_t           cur,
    output logic [CNT_W-1:0] val,
    output logic             zero_flag
);
    always_comb begin
        unique case (cur)
            ST_ZERO: begin
                val       = cur;
                zero_flag = 1'b1;
            end
            ST_BAD6, ST_BAD7: begin
                val       = ERR_PATTERN;
                zero_flag = 1'b0;
            end
            default: begin
                val       = cur;
                zero_flag = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mod6_counter.sv
module mod6_counter
    import mod6_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             tst_load,
    input  logic [CNT_W-1:0] tst_state,
    output logic [CNT_W-1:0] count_val,
    output logic             carry
);
    state_t state_q;
    state_t state_d;

    mod6_next u_next (
        .cur     (state_q),
        .rst     (rst),
        .en      (cnt_en),
        .ld      (tst_load),
        .ld_code (tst_state),
        .nxt     (state_d)
    );

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    mod6_decode u_decode (
        .cur       (state_q),
        .val       (count_val),
        .zero_flag (carry)
    );

    // ---------------- assertions ----------------
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: sampled mid-cycle after a reset edge
    always @(negedge clk) begin
        if (rst_d === 1'b1) begin
            a_r1_reset_zero: assert (count_val == '0 && carry == 1'b1)
                else $error("R1 reset did not reach zero");
        end
    end

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!tst_load && cnt_en && state_q < ST_FIVE)
        |=> (state_q == state_t'($past(state_q) + 3'd1)));

    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (!tst_load && cnt_en && state_q == ST_FIVE)
        |=> (count_val == '0 && carry));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!tst_load && !cnt_en && state_q <= ST_FIVE)
        |=> $stable(count_val) && $stable(carry));

    a_r5_carry_zero: assert property (@(posedge clk) disable iff (rst)
        carry |-> (count_val == '0));

    a_r7_recover: assert property (@(posedge clk) disable iff (rst)
        (!tst_load && state_q >= ST_BAD6)
        |=> (state_q == ST_ZERO && carry));

    a_r8_err_flag: assert property (@(posedge clk) disable iff (rst)
        (state_q >= ST_BAD6) |-> (count_val == ERR_PATTERN && !carry));

    a_r9_preload: assert property (@(posedge clk) disable iff (rst)
        tst_load |=> (state_q == state_t'($past(tst_state))));
endmodule

// File: tb/mod6_counter_bench.sv
`timescale 1ns/1ps
module mod6_counter_bench;
    localparam real TCK = 4.0;   // 250 MHz

    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_en;
    logic       tst_load;
    logic [2:0] tst_state;
    logic [2:0] count_val;
    logic       carry;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(TCK/2) clk = ~clk;

    mod6_counter u_mod6_counter (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .tst_load  (tst_load),
        .tst_state (tst_state),
        .count_val (count_val),
        .carry     (carry)
    );

    // {enable, expected value, expected carry}, applied from the zero state
    localparam int NV = 17;
    localparam logic [4:0] VEC [NV] = '{
        {1'b1, 3'd1, 1'b0}, {1'b1, 3'd2, 1'b0}, {1'b0, 3'd2, 1'b0},
        {1'b1, 3'd3, 1'b0}, {1'b1, 3'd4, 1'b0}, {1'b0, 3'd4, 1'b0},
        {1'b1, 3'd5, 1'b0}, {1'b0, 3'd5, 1'b0}, {1'b1, 3'd0, 1'b1},
        {1'b0, 3'd0, 1'b1}, {1'b0, 3'd0, 1'b1}, {1'b1, 3'd1, 1'b0},
        {1'b1, 3'd2, 1'b0}, {1'b1, 3'd3, 1'b0}, {1'b1, 3'd4, 1'b0},
        {1'b1, 3'd5, 1'b0}, {1'b1, 3'd0, 1'b1}
    };

    task automatic check(input string tag, input logic [2:0] ev, input logic ec);
        n_checks++;
        if (count_val !== ev || carry !== ec) begin
            n_errors++;
            $display("FAIL %s: got val=%0d carry=%0b, expected val=%0d carry=%0b",
                     tag, count_val, carry, ev, ec);
        end
    endtask

    // drive after a falling edge, let one rising edge pass, sample at the next falling edge
    task automatic cycle(input logic r, input logic en, input logic ld, input logic [2:0] code);
        rst = r; cnt_en = en; tst_load = ld; tst_state = code;
        @(negedge clk);
    endtask

    initial begin
        #(TCK * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cnt_en = 1'b1; tst_load = 1'b0; tst_state = 3'd0;
        @(negedge clk);
        cycle(1'b1, 1'b1, 1'b0, 3'd0);
        check("R1 reset", 3'd0, 1'b1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            string tag;
            cycle(1'b0, VEC[i][4], 1'b0, 3'd0);
            if (!VEC[i][4])             tag = "R4 hold";
            else if (VEC[i][3:1] == 0)  tag = "R3 wrap";
            else                        tag = "R2 step";
            check(tag, VEC[i][3:1], VEC[i][0]);
            if (VEC[i][3:1] != 0) check("R6 value", VEC[i][3:1], 1'b0);
            else                  check("R5 carry", 3'd0, 1'b1);
        end

        // R9: preload a valid code with enable high
        cycle(1'b0, 1'b1, 1'b1, 3'd3);
        check("R9 preload", 3'd3, 1'b0);

        // R10: enable toggling between edges moves no output
        rst = 1'b0; tst_load = 1'b0; cnt_en = 1'b0;
        #(TCK/4);
        check("R10 no comb path", 3'd3, 1'b0);
        cnt_en = 1'b1;
        #(TCK/8);
        check("R10 no comb path", 3'd3, 1'b0);
        @(negedge clk);
        check("R2 step after toggle", 3'd4, 1'b0);

        // spare code 110, enable low
        cycle(1'b0, 1'b0, 1'b1, 3'd6);
        check("R8 flag 110", 3'd7, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 3'd0);
        check("R7 recover 110 en=0", 3'd0, 1'b1);
        // spare code 110, enable high
        cycle(1'b0, 1'b1, 1'b1, 3'd6);
        check("R8 flag 110", 3'd7, 1'b0);
        cycle(1'b0, 1'b1, 1'b0, 3'd0);
        check("R7 recover 110 en=1", 3'd0, 1'b1);
        // spare code 111, both enables
        cycle(1'b0, 1'b0, 1'b1, 3'd7);
        check("R8 flag 111", 3'd7, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 3'd0);
        check("R7 recover 111 en=0", 3'd0, 1'b1);
        cycle(1'b0, 1'b1, 1'b1, 3'd7);
        check("R8 flag 111", 3'd7, 1'b0);
        cycle(1'b0, 1'b1, 1'b0, 3'd0);
        check("R7 recover 111 en=1", 3'd0, 1'b1);
        cycle(1'b0, 1'b1, 1'b0, 3'd0);
        check("R2 step after recovery", 3'd1, 1'b0);

        // R1: reset wins over preload
        cycle(1'b1, 1'b1, 1'b1, 3'd5);
        check("R1 reset over preload", 3'd0, 1'b1);
        cycle(1'b0, 1'b0, 1'b0, 3'd0);
        check("R5 carry held at zero", 3'd0, 1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule